// File: doc/BRIEF.md
# Two-Processor Snooping Coherence Subsystem with Abort and Retry

This block joins two processor request ports to one shared memory through a pair of direct-mapped, write-back cache controllers on a common bus. Each controller keeps a three-state (Invalid, Shared, Modified) record per line and watches the other controller's bus transactions. A write gains exclusive ownership and invalidates the peer copy. When a controller holds a line dirty and sees the peer try to read it, it does not supply the data. Instead it cancels that transaction in its first bus cycle, writes the line back to memory, and drops to Shared or Invalid. The cancelled controller then waits for that write-back to finish and tries again.

Each processor port takes one request at a time through a valid/ready handshake. A one-cycle `done` pulse marks completion, and read data is returned with it. The bus is a single, non-split resource, and each transaction holds it for a fixed number of cycles. A fixed-priority arbiter gives the bus to processor 0 when both controllers ask for it in the same cycle.

Top module: `msi_bus_top`

## Requirements
- R1: After reset, every line in both caches is Invalid and memory holds zero. The first access to any address therefore misses, taking more than one cycle, and a read returns 0.
- R2: A read that finds its line Shared or Modified, or a write that finds its line Modified, completes with no bus transaction. Its `done` pulse appears in the cycle after acceptance.
- R3: A read miss fetches the word from memory with a shared-read transaction and leaves the line Shared. This also holds when a Shared peer copy exists, and then no abort occurs.
- R4: A write to a line held Invalid or Shared issues an exclusive-read transaction and leaves the line Modified. A Shared copy in the peer becomes Invalid, so the peer's next read of that address misses.
- R5: A controller holding a line Modified asserts abort during the first bus cycle of a peer shared-read or exclusive-read to that line. That transaction then ends in that cycle.
- R6: After an abort, the aborting controller writes its line back to memory. It then holds the line Shared if the cancelled transaction was a shared-read, or Invalid if it was an exclusive-read.
- R7: The cancelled controller keeps its request pending and stays off the bus until the peer's write-back completes, then retries. Its processor stalls longer than on an uncontended miss and receives the written-back value.
- R8: When both controllers request an idle bus in the same cycle, processor 0 is served first.
- R9: A miss whose set holds a different Modified line writes that victim to memory before fetching. A Shared victim is replaced without any write-back, so the miss costs the same as an uncontended miss.
- R10: The two caches never hold the same line both Modified, or one Modified and one Shared. Every read returns the most recently written value.
- R11: Only one controller owns the bus at a time. Ownership lasts exactly BUS_LAT cycles unless the transaction is aborted in its first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 2 | Request present, one bit per processor |
| cpu_ready | output | 2 | Controller can accept a request this cycle |
| cpu_write | input | 2 | 1 = write, 0 = read, per processor |
| cpu_addr | input | 2*ADDR_W | Word address; processor 0 in the low slice. Low INDEX_W bits select the set |
| cpu_wdata | input | 2*DATA_W | Write data, processor 0 in the low slice |
| cpu_done | output | 2 | One-cycle completion pulse per processor |
| cpu_rdata | output | 2*DATA_W | Read data valid with `done`; 0 for writes |

## Verification
The bench builds the block with ADDR_W=6, INDEX_W=2, DATA_W=16 and BUS_LAT=2. With only four sets, addresses 0x05 and 0x15 fall in the same set, so dirty and clean evictions are easy to reach. The latency of an uncontended miss is measured once and used as the yardstick for the other cases. This lets the abort-retry stall, the victim write-back cost and the loss of arbitration by processor 1 all be judged by comparing completion times at the ports.

// File: rtl/msi_pkg.sv
// Shared encodings for the coherence subsystem.
// Assumes: two-bit line state and two-bit bus command are sufficient.
package msi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHD = 2'd1,
        LS_MOD = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_IDLE  = 2'd0,
        BC_READ  = 2'd1,
        BC_READX = 2'd2,
        BC_WBACK = 2'd3
    } bus_cmd_t;

endpackage

// File: rtl/msi_arbiter.sv
// Fixed-priority bus arbiter and transaction timer.
// Grants an idle bus to the lowest-numbered requester, holds ownership for
// BUS_LAT cycles, and releases the bus early when abort is seen in the first
// cycle. Assumes requesters keep their command stable while granted.
module msi_arbiter #(
    parameter int NREQ    = 2,
    parameter int BUS_LAT = 2,
    localparam int OWN_W  = (NREQ > 1) ? $clog2(NREQ) : 1,
    localparam int CNT_W  = (BUS_LAT > 1) ? $clog2(BUS_LAT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  req,
    input  logic             abort,
    output logic             busy,
    output logic [OWN_W-1:0] owner,
    output logic             first,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUS_LAT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [OWN_W-1:0] win;

    // Pick the lowest-numbered active request.
    always_comb begin
        win = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) win = OWN_W'(i);
        end
    end

    assign first = busy && (cnt_q == '0);
    assign done  = busy && (cnt_q == LAST) && !(first && abort);

    // Grant, count the transaction beats, release at the end or on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            owner <= '0;
            cnt_q <= '0;
        end else if (!busy) begin
            if (|req) begin
                busy  <= 1'b1;
                owner <= win;
                cnt_q <= '0;
            end
        end else if ((first && abort) || (cnt_q == LAST)) begin
            busy <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_IDLE_REQ_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && |req) |=> busy);                                   // R11
    AST_CPU0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req[0]) |=> (owner == '0));                        // R8
    AST_ABORT_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (first && abort) |=> !busy);                                 // R5
    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !(first && abort)) |=> (busy && $stable(owner))); // R11

endmodule

// File: rtl/msi_memory.sv
// Backing store: one word per address, zero after reset.
// Reads are combinational on the bus address; write-backs land at the
// final beat of a write-back transaction.
module msi_memory #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rdata = mem_q[addr];

    // Clear on reset, store write-back data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

endmodule

// File: rtl/msi_cache.sv
// Direct-mapped write-back cache controller with MSI snooping.
// One processor request in flight at a time. Snoops the peer's bus traffic:
// aborts peer reads of its Modified lines, then writes them back with priority
// over its own request. After being aborted it stays off the bus until the
// peer's write-back completes. Assumes one peer and a non-split bus.
module msi_cache
    import msi_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int INDEX_W = 2,
    parameter int DATA_W  = 16,
    localparam int SETS   = 1 << INDEX_W,
    localparam int TAG_W  = ADDR_W - INDEX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    // processor side
    input  logic                cpu_valid,
    output logic                cpu_ready,
    input  logic                cpu_write,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic                cpu_done,
    output logic [DATA_W-1:0]   cpu_rdata,
    // own bus request
    output logic                bus_req,
    output bus_cmd_t            bus_cmd_o,
    output logic [ADDR_W-1:0]   bus_addr_o,
    output logic [DATA_W-1:0]   bus_wdata_o,
    // shared bus view
    input  logic                bus_gnt,
    input  logic                bus_busy,
    input  logic                bus_first,
    input  logic                bus_done,
    input  bus_cmd_t            bus_cmd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_abort,
    output logic                snoop_abort,
    // line state view for the coherence checker
    output logic [2*SETS-1:0]   dbg_state,
    output logic [TAG_W*SETS-1:0] dbg_tag
);

    typedef enum logic {CS_IDLE, CS_MISS} cst_t;

    line_st_t            st_q  [SETS];
    logic [TAG_W-1:0]    tag_q [SETS];
    logic [DATA_W-1:0]   dat_q [SETS];

    cst_t                cs_q;
    logic                op_write_q;
    logic [ADDR_W-1:0]   op_addr_q;
    logic [DATA_W-1:0]   op_wdata_q;

    logic                wb_pend_q;
    logic [INDEX_W-1:0]  wb_idx_q;
    line_st_t            wb_next_q;
    logic                blk_q;

    logic [INDEX_W-1:0]  c_idx, m_idx, s_idx;
    logic [TAG_W-1:0]    c_tag, m_tag, s_tag;
    logic                c_hit, accept, victim_dirty, s_own;

    // Decode the processor, pending-miss and snoop addresses.
    always_comb begin
        c_idx = cpu_addr[INDEX_W-1:0];
        c_tag = cpu_addr[ADDR_W-1:INDEX_W];
        m_idx = op_addr_q[INDEX_W-1:0];
        m_tag = op_addr_q[ADDR_W-1:INDEX_W];
        s_idx = bus_addr[INDEX_W-1:0];
        s_tag = bus_addr[ADDR_W-1:INDEX_W];
    end

    assign cpu_ready = (cs_q == CS_IDLE) && !wb_pend_q;
    assign accept    = cpu_valid && cpu_ready;
    assign c_hit     = (tag_q[c_idx] == c_tag) &&
                       (cpu_write ? (st_q[c_idx] == LS_MOD) : (st_q[c_idx] != LS_INV));
    assign victim_dirty = (st_q[m_idx] == LS_MOD) && (tag_q[m_idx] != m_tag);

    // Snoop match on a peer transaction and abort on a dirty hit.
    assign s_own = bus_busy && !bus_gnt && (st_q[s_idx] != LS_INV) && (tag_q[s_idx] == s_tag);
    assign snoop_abort = s_own && bus_first && (st_q[s_idx] == LS_MOD) &&
                         ((bus_cmd == BC_READ) || (bus_cmd == BC_READX));

    // Choose the bus request: snoop write-back, victim write-back, then fill.
    always_comb begin
        bus_req     = 1'b0;
        bus_cmd_o   = BC_IDLE;
        bus_addr_o  = op_addr_q;
        bus_wdata_o = op_wdata_q;
        if (wb_pend_q) begin
            bus_req     = 1'b1;
            bus_cmd_o   = BC_WBACK;
            bus_addr_o  = {tag_q[wb_idx_q], wb_idx_q};
            bus_wdata_o = dat_q[wb_idx_q];
        end else if ((cs_q == CS_MISS) && !blk_q) begin
            bus_req = 1'b1;
            if (victim_dirty) begin
                bus_cmd_o   = BC_WBACK;
                bus_addr_o  = {tag_q[m_idx], m_idx};
                bus_wdata_o = dat_q[m_idx];
            end else begin
                bus_cmd_o = op_write_q ? BC_READX : BC_READ;
            end
        end
    end

    // Line array: fills, write-back downgrades, snoop invalidation, write hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                st_q[i]  <= LS_INV;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            if (bus_gnt && bus_done) begin
                case (bus_cmd)
                    BC_READ: begin
                        st_q[m_idx]  <= LS_SHD;
                        tag_q[m_idx] <= m_tag;
                        dat_q[m_idx] <= bus_rdata;
                    end
                    BC_READX: begin
                        st_q[m_idx]  <= LS_MOD;
                        tag_q[m_idx] <= m_tag;
                        dat_q[m_idx] <= op_wdata_q;
                    end
                    BC_WBACK: begin
                        if (wb_pend_q) st_q[wb_idx_q] <= wb_next_q;
                        else           st_q[m_idx]    <= LS_INV;
                    end
                    default: ;
                endcase
            end
            if (s_own && bus_done && (bus_cmd == BC_READX) && (st_q[s_idx] == LS_SHD))
                st_q[s_idx] <= LS_INV;
            if (accept && cpu_write && c_hit)
                dat_q[c_idx] <= cpu_wdata;
        end
    end

    // Record a pending snoop write-back and the state to fall to afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_pend_q <= 1'b0;
            wb_idx_q  <= '0;
            wb_next_q <= LS_INV;
        end else if (snoop_abort) begin
            wb_pend_q <= 1'b1;
            wb_idx_q  <= s_idx;
            wb_next_q <= (bus_cmd == BC_READ) ? LS_SHD : LS_INV;
        end else if (bus_gnt && bus_done && wb_pend_q) begin
            wb_pend_q <= 1'b0;
        end
    end

    // Block retry after being aborted until the peer's write-back lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= 1'b0;
        end else if (bus_gnt && bus_first && bus_abort) begin
            blk_q <= 1'b1;
        end else if (bus_busy && !bus_gnt && bus_done && (bus_cmd == BC_WBACK)) begin
            blk_q <= 1'b0;
        end
    end

    // Processor handshake: hits answer at once, misses wait for their fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q       <= CS_IDLE;
            cpu_done   <= 1'b0;
            cpu_rdata  <= '0;
            op_write_q <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
        end else begin
            cpu_done <= 1'b0;
            case (cs_q)
                CS_IDLE: begin
                    if (accept) begin
                        if (c_hit) begin
                            cpu_done  <= 1'b1;
                            cpu_rdata <= cpu_write ? '0 : dat_q[c_idx];
                        end else begin
                            cs_q       <= CS_MISS;
                            op_write_q <= cpu_write;
                            op_addr_q  <= cpu_addr;
                            op_wdata_q <= cpu_wdata;
                        end
                    end
                end
                default: begin
                    if (bus_gnt && bus_done && !wb_pend_q && (bus_cmd != BC_WBACK)) begin
                        cpu_done  <= 1'b1;
                        cpu_rdata <= (bus_cmd == BC_READ) ? bus_rdata : '0;
                        cs_q      <= CS_IDLE;
                    end
                end
            endcase
        end
    end

    // Flatten the line state for the coherence checker.
    always_comb begin
        for (int i = 0; i < SETS; i++) begin
            dbg_state[2*i +: 2]     = st_q[i];
            dbg_tag[TAG_W*i +: TAG_W] = tag_q[i];
        end
    end

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && c_hit) |=> cpu_done);                             // R2
    AST_ABORT_QUEUES_WB: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_abort |=> (wb_pend_q && bus_req && (bus_cmd_o == BC_WBACK))); // R6
    AST_ABORTED_LEAVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_first && bus_abort) |=> !bus_gnt);           // R7
    AST_WB_DROPS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_done && wb_pend_q) |=> (st_q[$past(wb_idx_q)] != LS_MOD)); // R6

endmodule

// File: rtl/msi_bus_top.sv
// Two-processor coherence subsystem: two snooping caches, the fixed-priority
// arbiter and the memory joined by a shared bus multiplexed by the owner.
// Assumes each processor keeps at most one request outstanding.
module msi_bus_top
    import msi_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int INDEX_W = 2,
    parameter int DATA_W  = 16,
    parameter int BUS_LAT = 2,
    localparam int NCPU   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCPU-1:0]        cpu_valid,
    output logic [NCPU-1:0]        cpu_ready,
    input  logic [NCPU-1:0]        cpu_write,
    input  logic [NCPU*ADDR_W-1:0] cpu_addr,
    input  logic [NCPU*DATA_W-1:0] cpu_wdata,
    output logic [NCPU-1:0]        cpu_done,
    output logic [NCPU*DATA_W-1:0] cpu_rdata
);

    localparam int SETS  = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - INDEX_W;
    localparam int OWN_W = $clog2(NCPU);

    logic [NCPU-1:0]   req_v, abort_v;
    bus_cmd_t          cmd_a   [NCPU];
    logic [ADDR_W-1:0] addr_a  [NCPU];
    logic [DATA_W-1:0] wd_a    [NCPU];
    logic [2*SETS-1:0] st_dbg  [NCPU];
    logic [TAG_W*SETS-1:0] tag_dbg [NCPU];

    logic              bus_busy, bus_first, bus_done, bus_abort;
    logic [OWN_W-1:0]  bus_owner;
    bus_cmd_t          bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wd, bus_rdata;

    // Drive the shared bus from the current owner.
    always_comb begin
        bus_cmd  = bus_busy ? cmd_a[bus_owner] : BC_IDLE;
        bus_addr = addr_a[bus_owner];
        bus_wd   = wd_a[bus_owner];
    end
    assign bus_abort = |abort_v;

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        msi_cache #(
            .ADDR_W (ADDR_W),
            .INDEX_W(INDEX_W),
            .DATA_W (DATA_W)
        ) u_cache (
            .clk        (clk),
            .rst_n      (rst_n),
            .cpu_valid  (cpu_valid[g]),
            .cpu_ready  (cpu_ready[g]),
            .cpu_write  (cpu_write[g]),
            .cpu_addr   (cpu_addr[g*ADDR_W +: ADDR_W]),
            .cpu_wdata  (cpu_wdata[g*DATA_W +: DATA_W]),
            .cpu_done   (cpu_done[g]),
            .cpu_rdata  (cpu_rdata[g*DATA_W +: DATA_W]),
            .bus_req    (req_v[g]),
            .bus_cmd_o  (cmd_a[g]),
            .bus_addr_o (addr_a[g]),
            .bus_wdata_o(wd_a[g]),
            .bus_gnt    (bus_busy && (bus_owner == OWN_W'(g))),
            .bus_busy   (bus_busy),
            .bus_first  (bus_first),
            .bus_done   (bus_done),
            .bus_cmd    (bus_cmd),
            .bus_addr   (bus_addr),
            .bus_rdata  (bus_rdata),
            .bus_abort  (bus_abort),
            .snoop_abort(abort_v[g]),
            .dbg_state  (st_dbg[g]),
            .dbg_tag    (tag_dbg[g])
        );
    end

    msi_arbiter #(
        .NREQ   (NCPU),
        .BUS_LAT(BUS_LAT)
    ) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req_v),
        .abort(bus_abort),
        .busy (bus_busy),
        .owner(bus_owner),
        .first(bus_first),
        .done (bus_done)
    );

    msi_memory #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(bus_done && (bus_cmd == BC_WBACK)),
        .addr (bus_addr),
        .wdata(bus_wd),
        .rdata(bus_rdata)
    );

    // Flag any set where both caches hold the same tag with a dirty copy.
    logic coh_viol;
    always_comb begin
        coh_viol = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            if (tag_dbg[0][TAG_W*s +: TAG_W] == tag_dbg[1][TAG_W*s +: TAG_W]) begin
                if ((st_dbg[0][2*s +: 2] == 2'(LS_MOD) && st_dbg[1][2*s +: 2] != 2'(LS_INV)) ||
                    (st_dbg[1][2*s +: 2] == 2'(LS_MOD) && st_dbg[0][2*s +: 2] != 2'(LS_INV)))
                    coh_viol = 1'b1;
            end
        end
    end

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !coh_viol);                                                  // R10

endmodule

// File: tb/tb_msi_bus_top.sv
`timescale 1ns/1ps
module tb_msi_bus_top;

    localparam int AW = 6, IW = 2, DW = 16, LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic v0 = 0, v1 = 0, w0 = 0, w1 = 0;
    logic [AW-1:0] a0 = '0, a1 = '0;
    logic [DW-1:0] d0 = '0, d1 = '0;
    logic [1:0] ready, done;
    logic [2*DW-1:0] rdata;

    msi_bus_top #(.ADDR_W(AW), .INDEX_W(IW), .DATA_W(DW), .BUS_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid({v1, v0}), .cpu_ready(ready), .cpu_write({w1, w0}),
        .cpu_addr({a1, a0}), .cpu_wdata({d1, d0}),
        .cpu_done(done), .cpu_rdata(rdata)
    );

    typedef struct {
        bit          rd;
        logic [DW-1:0] val;
        string       rq;
    } item_t;

    item_t q0[$];
    item_t q1[$];
    logic [DW-1:0] ref_mem [1<<AW];
    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Driver: push the expected item, handshake, measure cycles to done.
    task automatic run_op(input int p, input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input string rq, output int lat);
        item_t it;
        it.rd = !wr;
        it.val = wr ? '0 : ref_mem[a];
        it.rq = rq;
        if (wr) ref_mem[a] = d;
        if (p == 0) begin q0.push_back(it); v0 = 1; w0 = wr; a0 = a; d0 = d; end
        else        begin q1.push_back(it); v1 = 1; w1 = wr; a1 = a; d1 = d; end
        while (!ready[p]) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        if (p == 0) v0 = 0; else v1 = 0;
        lat = 1;
        while (!done[p]) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Monitor: pop and compare on every completion.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (done[p]) begin
                    item_t it;
                    if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
                        chk(1'b0, "R2", "unexpected done", 1, 0);
                    end else begin
                        it = (p == 0) ? q0.pop_front() : q1.pop_front();
                        if (it.rd)
                            chk(rdata[p*DW +: DW] == it.val, it.rq, "read data",
                                int'(rdata[p*DW +: DW]), int'(it.val));
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    localparam logic [AW-1:0] A_ADR = 6'h05, B_ADR = 6'h15, C_ADR = 6'h0A,
                              D_ADR = 6'h03, E_ADR = 6'h0E;

    initial begin
        int lat, lat_plain, lat_ab, lat0, lat1;
        for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ready == 2'b11, "R1", "ready after reset", int'(ready), 3);
        chk(done == 2'b00, "R1", "done after reset", int'(done), 0);

        // R1/R3: cold misses return zero
        run_op(0, 0, A_ADR, '0, "R1", lat_plain);
        chk(lat_plain > 1, "R1", "cold miss latency", lat_plain, 2);
        run_op(1, 0, C_ADR, '0, "R1", lat);
        chk(lat == lat_plain, "R3", "miss latency cpu1", lat, lat_plain);
        // R2: read hit
        run_op(0, 0, A_ADR, '0, "R2", lat);
        chk(lat == 1, "R2", "read hit latency", lat, 1);
        // R3: shared peer copy, no abort
        run_op(1, 0, A_ADR, '0, "R3", lat);
        chk(lat == lat_plain, "R3", "read miss with shared peer", lat, lat_plain);
        // R4: upgrade then write hit
        run_op(1, 1, A_ADR, 16'h1111, "R4", lat);
        chk(lat > 1, "R4", "upgrade latency", lat, 2);
        run_op(1, 1, A_ADR, 16'h2222, "R2", lat);
        chk(lat == 1, "R2", "write hit latency", lat, 1);
        // R4/R5/R7: invalidated cpu0 reads, aborted by dirty cpu1
        run_op(0, 0, A_ADR, '0, "R7", lat_ab);
        chk(lat_ab > lat_plain, "R5", "abort-retry stall", lat_ab, lat_plain + 1);
        // R6: cpu1 dropped to Shared, so a read hits
        run_op(1, 0, A_ADR, '0, "R6", lat);
        chk(lat == 1, "R6", "shared after write-back", lat, 1);
        // R4/R6: exclusive read aborted, dirty owner goes Invalid
        run_op(1, 1, A_ADR, 16'h3333, "R4", lat);
        run_op(0, 1, A_ADR, 16'h4444, "R6", lat);
        chk(lat > lat_plain, "R6", "write aborted then retried", lat, lat_plain + 1);
        run_op(1, 0, A_ADR, '0, "R7", lat);
        chk(lat > lat_plain, "R7", "read of peer dirty line", lat, lat_plain + 1);
        // R9: dirty victim write-back, then clean victim
        run_op(0, 1, A_ADR, 16'h5555, "R4", lat);
        run_op(0, 0, B_ADR, '0, "R9", lat);
        chk(lat > lat_plain, "R9", "dirty victim cost", lat, lat_plain + 1);
        run_op(1, 0, A_ADR, '0, "R9", lat);
        chk(lat == lat_plain, "R9", "evicted line served from memory", lat, lat_plain);
        run_op(0, 0, B_ADR, '0, "R2", lat);
        chk(lat == 1, "R2", "hit after fill", lat, 1);
        run_op(0, 0, A_ADR, '0, "R9", lat);
        chk(lat == lat_plain, "R9", "clean victim no write-back", lat, lat_plain);
        // R8: simultaneous misses, cpu0 first
        @(negedge clk);
        fork
            run_op(0, 0, D_ADR, '0, "R8", lat0);
            run_op(1, 0, E_ADR, '0, "R8", lat1);
        join
        chk(lat0 == lat_plain, "R8", "cpu0 latency", lat0, lat_plain);
        chk(lat1 > lat0, "R8", "cpu1 served second", lat1, lat0 + 1);
        // R10: concurrent writes then cross reads see newest values
        @(negedge clk);
        fork
            run_op(0, 1, D_ADR, 16'h0D0D, "R10", lat0);
            run_op(1, 1, E_ADR, 16'h0E0E, "R10", lat1);
        join
        run_op(1, 0, D_ADR, '0, "R10", lat);
        run_op(0, 0, E_ADR, '0, "R10", lat);
        run_op(1, 0, E_ADR, '0, "R10", lat);
        chk(lat == 1, "R6", "write-back leaves owner shared", lat, 1);

        repeat (4) @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R11", "outstanding items",
            q0.size() + q1.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule